// File: doc/BRIEF.md
# I2C Slave Address Front End with General Call

This block is the receive side of an I2C slave. It watches already-synchronized SCL and SDA, detects START, repeated START and STOP conditions, and shifts one bit in on every rising SCL edge. The first byte after a START is the address byte. It is compared in parallel against a programmable own address and against the fixed general call value of 0x00. When a byte is accepted, the block copies it into a receive buffer and raises a buffer-full flag. It pulls SDA low for the acknowledge clock and pulses an interrupt when that clock ends.

Both 7-bit and 10-bit slave addressing are supported. In 10-bit mode a matching first byte raises an update-address flag. Software then reloads the own-address input with the low address byte before the second byte arrives. If a general call arrives in 10-bit mode, the second address byte is skipped and the block goes straight to data reception without raising the update-address flag. The buffer keeps the address byte, so software can read it to tell a general call from a device-specific match.

The controller is a single state machine with these states:
- ST_IDLE: ignore the bus.
- ST_ADDR: shift the first address byte.
- ST_ADDR2: shift the second 10-bit address byte.
- ST_DATA: shift a data byte.
- ST_ACK_SETUP: wait for the falling edge of the 8th clock.
- ST_ACK_DRIVE: wait for the 9th rising edge.
- ST_ACK_END: wait for the falling edge that ends the 9th clock.

It has these transitions:
- START from any state goes to ST_ADDR.
- STOP from any state goes to ST_IDLE.
- The 8th rising edge in a shift state goes to ST_ACK_SETUP.
- A falling edge goes from ST_ACK_SETUP to ST_ACK_DRIVE.
- A rising edge goes from ST_ACK_DRIVE to ST_ACK_END.
- A falling edge in ST_ACK_END goes to one of three states:
  - ST_DATA, after an accepted general call, an accepted 7-bit match, an accepted second 10-bit byte, or an accepted data byte.
  - ST_ADDR2, after an accepted first 10-bit byte.
  - ST_IDLE, after any byte that was not acknowledged.

Top module: `i2c_gc_rx_front`

## Requirements
- R1: A falling SDA while SCL is high is a START. A rising SDA while SCL is high is a STOP. After a START, bits are shifted MSB first on rising SCL. A START seen without a preceding STOP (repeated START) restarts address reception.
- R2: In 7-bit mode (ten_bit_i=0), an address byte whose bits [7:1] equal own_addr_i[7:1] and whose bit 0 (R/W) is 0 is acknowledged. A byte with R/W=1 is not acknowledged.
- R3: The address byte 0x00 (general call) is acknowledged only while gc_en_i=1. While gc_en_i=0 it is not acknowledged.
- R4: For an accepted byte, buf_full_o rises after the 8th rising SCL and rx_buf_o holds the byte. A one-cycle buf_rd_i pulse clears buf_full_o.
- R5: sda_low_o is asserted only for accepted bytes. It rises after the falling SCL that ends the 8th bit and falls after the falling SCL that ends the 9th bit.
- R6: irq_o is a one-cycle pulse, issued only after the falling SCL that ends an acknowledged 9th clock.
- R7: In 10-bit mode, a first byte with bits [7:3]=11110, bits [7:1] equal to own_addr_i[7:1] and R/W=0 is acknowledged and sets upd_addr_o. The second byte is acknowledged only if all 8 bits equal own_addr_i. upd_addr_o clears when the second byte completes.
- R8: In 10-bit mode, an accepted general call leaves upd_addr_o clear, and the next byte is taken as data.
- R9: A byte that completes while buf_full_o=1 sets ovf_o, is not acknowledged and leaves rx_buf_o unchanged. buf_rd_i clears ovf_o.
- R10: After a STOP, or after any byte that was not acknowledged, bytes are ignored until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level |
| own_addr_i | input | 8 | Own address (bits [7:1] for a first byte, all 8 bits for the 10-bit second byte) |
| gc_en_i | input | 1 | General call recognition enable |
| ten_bit_i | input | 1 | 1 = 10-bit addressing, 0 = 7-bit |
| buf_rd_i | input | 1 | Buffer read strobe; clears buf_full_o and ovf_o |
| sda_low_o | output | 1 | Pull SDA low (acknowledge) |
| rx_buf_o | output | 8 | Receive buffer |
| buf_full_o | output | 1 | Buffer holds an unread byte |
| ovf_o | output | 1 | Byte arrived while buffer was full |
| upd_addr_o | output | 1 | Reload own address for the second 10-bit byte |
| irq_o | output | 1 | One-cycle interrupt pulse after an acknowledged byte |

## Verification
A wrong state or bit count shows up on the acknowledge clock of the same byte. SDA is either not pulled low when it should be, or pulled low when it should not be. The buffer and buf_full_o show the error within one system cycle of the 8th rising SCL. A wrong next-state choice after the acknowledge, such as expecting a second address byte after a general call, shows on the very next byte as a missing or unexpected acknowledge. A wrong upd_addr_o shows after the first 10-bit byte. Overflow and idle-until-START faults are exposed by sending a byte that must be refused and checking that the buffer and flags are unchanged.

// File: rtl/i2c_gc_pkg.sv
package i2c_gc_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR2,
        ST_DATA,
        ST_ACK_SETUP,
        ST_ACK_DRIVE,
        ST_ACK_END
    } rx_state_t;
endpackage

// File: rtl/i2c_gc_bus_cond.sv
module i2c_gc_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign scl_rise_o = scl_i & ~scl_q;
    assign scl_fall_o = ~scl_i & scl_q;
    assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
    assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2c_gc_addr_cmp.sv
module i2c_gc_addr_cmp #(
    parameter int BW = 8
) (
    input  logic [BW-1:0] rx_byte_i,
    input  logic [BW-1:0] own_addr_i,
    input  logic          gc_en_i,
    output logic          own7_hit_o,
    output logic          hi10_hit_o,
    output logic          lo10_hit_o,
    output logic          gc_hit_o
);
    localparam int          PFX_W  = 5;
    localparam logic [4:0]  PFX_10 = 5'b11110;

    logic upper_eq;

    assign upper_eq   = (rx_byte_i[BW-1:1] == own_addr_i[BW-1:1]);
    assign own7_hit_o = upper_eq & ~rx_byte_i[0];
    assign hi10_hit_o = upper_eq & ~rx_byte_i[0] & (rx_byte_i[BW-1 -: PFX_W] == PFX_10);
    assign lo10_hit_o = (rx_byte_i == own_addr_i);
    assign gc_hit_o   = gc_en_i & (rx_byte_i == '0);
endmodule

// File: rtl/i2c_gc_rx_front.sv
module i2c_gc_rx_front
    import i2c_gc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [BYTE_W-1:0] own_addr_i,
    input  logic              gc_en_i,
    input  logic              ten_bit_i,
    input  logic              buf_rd_i,
    output logic              sda_low_o,
    output logic [BYTE_W-1:0] rx_buf_o,
    output logic              buf_full_o,
    output logic              ovf_o,
    output logic              upd_addr_o,
    output logic              irq_o
);
    rx_state_t state_q, state_d;
    rx_state_t after_ack_q;

    logic [BYTE_W-1:0] shreg_q;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic              ack_q;
    logic [BYTE_W-1:0] rx_buf_q;
    logic              bf_q, ovf_q, ua_q, irq_q;

    logic scl_rise, scl_fall, start_det, stop_det;
    logic own7_hit, hi10_hit, lo10_hit, gc_hit;
    logic [BYTE_W-1:0] byte_now;
    logic shifting, last_bit;
    logic byte_hit;
    rx_state_t byte_next;

    i2c_gc_bus_cond u_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    assign byte_now = {shreg_q[BYTE_W-2:0], sda_i};

    i2c_gc_addr_cmp #(.BW(BYTE_W)) u_cmp (
        .rx_byte_i  (byte_now),
        .own_addr_i (own_addr_i),
        .gc_en_i    (gc_en_i),
        .own7_hit_o (own7_hit),
        .hi10_hit_o (hi10_hit),
        .lo10_hit_o (lo10_hit),
        .gc_hit_o   (gc_hit)
    );

    assign shifting = (state_q == ST_ADDR) || (state_q == ST_ADDR2) || (state_q == ST_DATA);
    assign last_bit = shifting && scl_rise && (bit_cnt_q == CNT_W'(BYTE_W - 1));

    // Match decision for the byte completing now, and where to go after its ACK
    always_comb begin
        byte_hit  = 1'b0;
        byte_next = ST_DATA;
        unique case (state_q)
            ST_ADDR: begin
                if (gc_hit) begin
                    byte_hit  = 1'b1;
                    byte_next = ST_DATA;
                end else if (ten_bit_i) begin
                    byte_hit  = hi10_hit;
                    byte_next = ST_ADDR2;
                end else begin
                    byte_hit  = own7_hit;
                    byte_next = ST_DATA;
                end
            end
            ST_ADDR2: begin
                byte_hit  = lo10_hit;
                byte_next = ST_DATA;
            end
            ST_DATA: begin
                byte_hit  = 1'b1;
                byte_next = ST_DATA;
            end
            default: begin
                byte_hit  = 1'b0;
                byte_next = ST_IDLE;
            end
        endcase
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (start_det) begin
            state_d = ST_ADDR;
        end else if (stop_det) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:      state_d = ST_IDLE;
                ST_ADDR,
                ST_ADDR2,
                ST_DATA:      if (last_bit) state_d = ST_ACK_SETUP;
                ST_ACK_SETUP: if (scl_fall) state_d = ST_ACK_DRIVE;
                ST_ACK_DRIVE: if (scl_rise) state_d = ST_ACK_END;
                ST_ACK_END:   if (scl_fall) state_d = ack_q ? after_ack_q : ST_IDLE;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Shift path, buffer and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q     <= '0;
            bit_cnt_q   <= '0;
            ack_q       <= 1'b0;
            after_ack_q <= ST_IDLE;
            rx_buf_q    <= '0;
            bf_q        <= 1'b0;
            ovf_q       <= 1'b0;
            ua_q        <= 1'b0;
            irq_q       <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (buf_rd_i) begin
                bf_q  <= 1'b0;
                ovf_q <= 1'b0;
            end
            if (start_det) begin
                bit_cnt_q <= '0;
                ack_q     <= 1'b0;
            end else if (!stop_det) begin
                if (shifting && scl_rise) begin
                    shreg_q   <= byte_now;
                    bit_cnt_q <= bit_cnt_q + 1'b1;
                end
                if (last_bit) begin
                    ack_q       <= byte_hit && !bf_q;
                    after_ack_q <= byte_next;
                    if (byte_hit && bf_q) ovf_q <= 1'b1;
                    if (byte_hit && !bf_q) begin
                        rx_buf_q <= byte_now;
                        bf_q     <= 1'b1;
                    end
                    if (state_q == ST_ADDR2) begin
                        ua_q <= 1'b0;
                    end else if (state_q == ST_ADDR && ten_bit_i && !gc_hit
                                 && hi10_hit && !bf_q) begin
                        ua_q <= 1'b1;
                    end
                end
                if (state_q == ST_ACK_END && scl_fall && ack_q) irq_q <= 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        sda_low_o  = ack_q && ((state_q == ST_ACK_DRIVE) || (state_q == ST_ACK_END));
        rx_buf_o   = rx_buf_q;
        buf_full_o = bf_q;
        ovf_o      = ovf_q;
        upd_addr_o = ua_q;
        irq_o      = irq_q;
    end
endmodule

// File: rtl/i2c_gc_rx_chk.sv
module i2c_gc_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_i,
    input logic       ten_bit_i,
    input logic       sda_low_o,
    input logic       buf_full_o,
    input logic       ovf_o,
    input logic       upd_addr_o,
    input logic       irq_o
);
    // R5
    ack_start_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_low_o) |-> !scl_i);

    // R5
    ack_stable_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i)) |-> $stable(sda_low_o));

    // R5
    ack_holds_bus_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_low_o && $past(sda_low_o)) |-> !sda_i);

    // R6
    irq_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    // R6
    irq_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !scl_i);

    // R4
    bf_set_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_full_o) |-> scl_i);

    // R7
    ua_only_ten_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(upd_addr_o) |-> ten_bit_i);

    // R9
    ovf_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_o) |-> $past(buf_full_o));
endmodule

bind i2c_gc_rx_front i2c_gc_rx_chk u_rx_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .ten_bit_i  (ten_bit_i),
    .sda_low_o  (sda_low_o),
    .buf_full_o (buf_full_o),
    .ovf_o      (ovf_o),
    .upd_addr_o (upd_addr_o),
    .irq_o      (irq_o)
);

// File: tb/test_i2c_gc_rx_front.sv
`timescale 1ns/1ps
module test_i2c_gc_rx_front;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic [7:0] own_addr = 8'h5A;
    logic       gc_en = 1'b0;
    logic       ten_bit = 1'b0;
    logic       buf_rd = 1'b0;
    logic       sda_low;
    logic [7:0] rx_buf;
    logic       buf_full, ovf, upd_addr, irq;
    wire        sda_bus = sda_m & ~sda_low;

    int checks = 0;
    int failures = 0;
    int irq_cnt = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    i2c_gc_rx_front i_i2c_gc_rx_front (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_bus),
        .own_addr_i (own_addr),
        .gc_en_i    (gc_en),
        .ten_bit_i  (ten_bit),
        .buf_rd_i   (buf_rd),
        .sda_low_o  (sda_low),
        .rx_buf_o   (rx_buf),
        .buf_full_o (buf_full),
        .ovf_o      (ovf),
        .upd_addr_o (upd_addr),
        .irq_o      (irq)
    );

    always @(negedge clk) if (rst_n && irq) irq_cnt <= irq_cnt + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        scl = 1'b0; cyc(1);
        sda_m = 1'b1; cyc(2);
        scl = 1'b1; cyc(4);
        sda_m = 1'b0; cyc(4);
        scl = 1'b0; cyc(2);
    endtask

    task automatic bus_stop();
        scl = 1'b0; cyc(1);
        sda_m = 1'b0; cyc(2);
        scl = 1'b1; cyc(4);
        sda_m = 1'b1; cyc(4);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked, output bit bf8);
        scl = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            cyc(2); sda_m = b[i]; cyc(2);
            scl = 1'b1; cyc(3);
            if (i == 0) bf8 = buf_full;
            cyc(1);
            scl = 1'b0;
        end
        cyc(2); sda_m = 1'b1; cyc(2);
        scl = 1'b1; cyc(2);
        acked = (sda_bus == 1'b0);
        cyc(2);
        scl = 1'b0; cyc(3);
    endtask

    task automatic read_buf();
        buf_rd = 1'b1; cyc(1);
        buf_rd = 1'b0; cyc(1);
    endtask

    task automatic t_reset();
        chk(sda_low == 0 && buf_full == 0 && ovf == 0 && upd_addr == 0 && irq == 0,
            "R5 reset outputs", {sda_low, buf_full, ovf, upd_addr, irq}, 0);
    endtask

    task automatic t_own7();
        bit a, f; int n0;
        n0 = irq_cnt;
        bus_start();
        send_byte(8'h5A, a, f);
        chk(a, "R2 own 7-bit address acked", a, 1);
        chk(f && rx_buf == 8'h5A, "R4 buffer at 8th bit", {f, rx_buf}, 9'h15A);
        chk(irq_cnt == n0 + 1, "R6 one irq per acked byte", irq_cnt - n0, 1);
        chk(sda_low == 0, "R5 ack released after 9th", sda_low, 0);
        read_buf();
        chk(buf_full == 0, "R4 read clears full", buf_full, 0);
        send_byte(8'hC3, a, f);
        chk(a && rx_buf == 8'hC3, "R1 data byte shifted MSB first", rx_buf, 8'hC3);
    endtask

    task automatic t_overflow();
        bit a, f; int n0;
        n0 = irq_cnt;
        send_byte(8'h11, a, f);
        chk(!a && ovf, "R9 overflow nack and flag", {a, ovf}, 1);
        chk(rx_buf == 8'hC3, "R9 buffer unchanged", rx_buf, 8'hC3);
        chk(irq_cnt == n0, "R6 no irq on nack", irq_cnt - n0, 0);
        read_buf();
        chk(ovf == 0 && buf_full == 0, "R9 read clears ovf", {ovf, buf_full}, 0);
        bus_stop();
    endtask

    task automatic t_mismatch_restart();
        bit a, f;
        bus_start();
        send_byte(8'h20, a, f);
        chk(!a && !buf_full, "R10 mismatch not acked", {a, buf_full}, 0);
        send_byte(8'h5A, a, f);
        chk(!a && !buf_full, "R10 idle ignores byte", {a, buf_full}, 0);
        bus_start();
        send_byte(8'h5A, a, f);
        chk(a && rx_buf == 8'h5A, "R1 repeated START restarts address", {a, rx_buf}, 9'h15A);
        read_buf();
        bus_stop();
        send_byte(8'h5A, a, f);
        chk(!a && !buf_full, "R10 ignored after STOP", {a, buf_full}, 0);
    endtask

    task automatic t_read_bit();
        bit a, f;
        bus_start();
        send_byte(8'h5B, a, f);
        chk(!a && !buf_full, "R2 R/W=1 not acked", {a, buf_full}, 0);
        bus_stop();
    endtask

    task automatic t_gc();
        bit a, f;
        gc_en = 1'b0;
        bus_start();
        send_byte(8'h00, a, f);
        chk(!a && !buf_full, "R3 gc disabled not acked", {a, buf_full}, 0);
        bus_stop();
        gc_en = 1'b1;
        bus_start();
        send_byte(8'h00, a, f);
        chk(a && f && rx_buf == 8'h00, "R3 gc enabled acked", {a, f}, 3);
        read_buf();
        send_byte(8'h44, a, f);
        chk(a && rx_buf == 8'h44, "R3 data after gc", rx_buf, 8'h44);
        read_buf();
        bus_stop();
        gc_en = 1'b0;
    endtask

    task automatic t_ten_bit();
        bit a, f;
        ten_bit = 1'b1; own_addr = 8'hF2;
        bus_start();
        send_byte(8'hF2, a, f);
        chk(a && upd_addr && rx_buf == 8'hF2, "R7 first 10-bit byte", {a, upd_addr}, 3);
        read_buf();
        own_addr = 8'h34;
        send_byte(8'h34, a, f);
        chk(a && !upd_addr && rx_buf == 8'h34, "R7 second 10-bit byte", {a, upd_addr}, 2);
        read_buf();
        send_byte(8'h99, a, f);
        chk(a && rx_buf == 8'h99, "R7 data after 10-bit address", rx_buf, 8'h99);
        read_buf();
        bus_stop();
        own_addr = 8'hF2;
        bus_start();
        send_byte(8'hF2, a, f);
        read_buf();
        own_addr = 8'h34;
        send_byte(8'h35, a, f);
        chk(!a && !upd_addr && !buf_full, "R7 second byte mismatch", {a, upd_addr}, 0);
        bus_stop();
    endtask

    task automatic t_ten_bit_gc();
        bit a, f;
        ten_bit = 1'b1; own_addr = 8'hF2; gc_en = 1'b1;
        bus_start();
        send_byte(8'h00, a, f);
        chk(a && !upd_addr, "R8 10-bit gc no update flag", {a, upd_addr}, 2);
        read_buf();
        send_byte(8'h77, a, f);
        chk(a && rx_buf == 8'h77, "R8 next byte is data", {a, rx_buf}, 9'h177);
        read_buf();
        bus_stop();
        gc_en = 1'b0; ten_bit = 1'b0; own_addr = 8'h5A;
    endtask

    initial begin
        cyc(4);
        t_reset();
        rst_n = 1'b1;
        cyc(4);
        t_own7();
        t_overflow();
        t_mismatch_restart();
        t_read_bit();
        t_gc();
        t_ten_bit();
        t_ten_bit_gc();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule